// File: doc/BRIEF.md
# Interrupt Claim/Complete Register Slave

This block is the software-visible register file of a platform interrupt controller. It holds a priority for every interrupt source, a pending bit for every source, an enable bitmap and a priority threshold for every target context, and a claim/complete register for each context. A simple valid/ready bus carries only aligned 32-bit accesses. Gateways raise one-cycle request strobes that set pending bits. The block sends one-cycle completion strobes back to the gateways when software reports that a source is done.

Per-context selectors sit outside the block. They read the pending bits, priorities, enables and thresholds from the block's outputs and return the winning source ID for each context. A read of a context's claim register returns that winner. In the same clock edge it clears the winner's pending bit. A write of an ID to the claim register is a completion. It is checked only against the writing context's enable bitmap and never against the last ID claimed. The default build has 31 sources (IDs 1 to 31, ID 0 meaning "none"), 2 contexts and 3-bit priorities.

Top module: `irq_claim_regs`

## Requirements
- R1: After synchronous reset, all priorities, enables, thresholds and pending bits are zero, `gw_done` is zero and `bus_rsp` is low.
- R2: The priority of source ID sits at byte offset 4×ID. Only the low PRIO_W (3) bits are stored, and the upper bits read as zero. Offset 0 (ID 0) reads zero and ignores writes. `src_prio` carries ID k+1 in bits [k×PRIO_W +: PRIO_W].
- R3: Pending bits are read at offset 0x1000 + 4×(ID/32), bit ID mod 32, and bit 0 always reads zero. A strobe on `gw_req[ID-1]` sets the pending bit at the clock edge where it is high. `src_pend[ID-1]` mirrors it.
- R4: Writes to the pending region change nothing. A pending bit falls only through a claim.
- R5: The enable word of context c sits at 0x2000 + 0x80×c, packed like the pending bits, and bit 0 reads zero. `ctx_en[c×NSRC + ID-1]` mirrors the enable bit.
- R6: The threshold of context c sits at 0x200000 + 0x1000×c. It keeps only the low PRIO_W bits, and the upper bits read zero. `ctx_thr[c×PRIO_W +: PRIO_W]` mirrors it.
- R7: A read of claim/complete at threshold address + 4 returns `sel_id` of that context (ID_W bits per context, context c at [c×ID_W +: ID_W]). The pending bit of that ID is clear from the same edge on. A winner of 0 returns 0 and clears nothing.
- R8: A write of ID to context c's claim/complete register, with 1 ≤ ID ≤ NSRC and ID enabled for c, gives a one-cycle pulse on `gw_done[ID-1]`. The pulse appears in the cycle after the write is accepted, whatever was claimed before.
- R9: A completion of an ID that is not enabled for the writing context is dropped. So is a completion of 0, or of any 32-bit value above NSRC.
- R10: When a gateway request and a claim of the same source share a cycle, the pending bit is clear after that edge and is set again one edge later.
- R11: Reads of unmapped aligned offsets return zero, and writes to them change no register.
- R12: `bus_ready` is always high. Every accepted access raises `bus_rsp` for the next cycle, with read data in `bus_rdata` (zero for writes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request |
| bus_ready | output | 1 | Access accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (26) | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rsp | output | 1 | Response strobe, one cycle after acceptance |
| bus_rdata | output | 32 | Read data, valid with `bus_rsp` |
| gw_req | input | NSRC | Gateway request strobes, bit k = ID k+1 |
| gw_done | output | NSRC | Completion strobes to gateways, bit k = ID k+1 |
| sel_id | input | NCTX×ID_W | Winning ID per context from the selectors |
| src_pend | output | NSRC | Pending bits, bit k = ID k+1 |
| src_prio | output | NSRC×PRIO_W | Source priorities |
| ctx_en | output | NCTX×NSRC | Enable bitmaps per context |
| ctx_thr | output | NCTX×PRIO_W | Threshold per context |

## Verification
The assertions assume that every aligned access falls on a word boundary. They also assume the selectors never return an ID above NSRC, because a claim uses that ID as a bit index into the pending vector. The stimulus keeps to both. It issues only word-aligned offsets, including the unmapped ones. It drives `sel_id` with 0 or with a source number that exists, and it holds every input low during reset.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_PRIO,
    REG_PEND,
    REG_EN,
    REG_THR,
    REG_CLAIM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [9:0]  idx;   // source ID or word index
    logic [7:0]  ctx;   // context number
  } reg_sel_t;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int NWORD  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  localparam logic [ADDR_W-1:0] PEND_BASE = ADDR_W'(32'h0000_1000);
  localparam logic [ADDR_W-1:0] EN_BASE   = ADDR_W'(32'h0000_2000);
  localparam logic [ADDR_W-1:0] EN_END    = ADDR_W'(32'h0000_2000 + 32'h80 * NCTX);
  localparam logic [ADDR_W-1:0] CTX_BASE  = ADDR_W'(32'h0020_0000);
  localparam logic [ADDR_W-1:0] CTX_END   = ADDR_W'(32'h0020_0000 + 32'h1000 * NCTX);

  logic [ADDR_W-1:0] en_off;
  logic [ADDR_W-1:0] ctx_off;

  assign en_off  = addr - EN_BASE;
  assign ctx_off = addr - CTX_BASE;

  always_comb begin
    sel.kind = REG_NONE;
    sel.idx  = '0;
    sel.ctx  = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr < PEND_BASE) begin
        if (addr[11:2] != 10'd0 && 32'(addr[11:2]) <= NSRC) begin
          sel.kind = REG_PRIO;
          sel.idx  = addr[11:2];
        end
      end else if (addr < EN_BASE) begin
        if (32'(addr[11:2]) < NWORD) begin
          sel.kind = REG_PEND;
          sel.idx  = addr[11:2];
        end
      end else if (addr < EN_END) begin
        if (32'(en_off[6:2]) < NWORD) begin
          sel.kind = REG_EN;
          sel.idx  = 10'(en_off[6:2]);
          sel.ctx  = 8'(en_off >> 7);
        end
      end else if (addr >= CTX_BASE && addr < CTX_END) begin
        sel.ctx = 8'(ctx_off >> 12);
        if (ctx_off[11:0] == 12'h000)      sel.kind = REG_THR;
        else if (ctx_off[11:0] == 12'h004) sel.kind = REG_CLAIM;
        else                               sel.ctx  = '0;
      end
    end
  end

endmodule

// File: rtl/irq_prio_file.sv
module irq_prio_file #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [ID_W-1:0]        wid,
  input  logic [PRIO_W-1:0]      wval,
  input  logic [ID_W-1:0]        rid,
  output logic [PRIO_W-1:0]      rval,
  output logic [NSRC*PRIO_W-1:0] prio_flat
);

  logic [PRIO_W-1:0] mem [NSRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NSRC; k++) mem[k] <= '0;
    end else if (we && wid != '0) begin
      mem[wid - 1'b1] <= wval;
    end
  end

  assign rval = (rid != '0) ? mem[rid - 1'b1] : '0;

  for (genvar k = 0; k < NSRC; k++) begin : g_flat
    assign prio_flat[k*PRIO_W +: PRIO_W] = mem[k];
  end

endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
  parameter int NSRC = 31,
  parameter int ID_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic            clr_hit,
  input  logic [ID_W-1:0] clr_id,
  output logic [NSRC-1:0] pend
);

  logic [NSRC-1:0] clr_mask;
  logic [NSRC-1:0] held;
  logic [NSRC-1:0] incoming;

  for (genvar k = 0; k < NSRC; k++) begin : g_clr
    assign clr_mask[k] = clr_hit && (clr_id == ID_W'(k + 1));
  end

  assign incoming = req | held;

  // A claim beats a same-cycle request; the request is replayed one edge later.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      held <= '0;
    end else begin
      pend <= (pend | incoming) & ~clr_mask;
      held <= incoming & clr_mask;
    end
  end

endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en_we,
  input  logic                   thr_we,
  input  logic [7:0]             ctx,
  input  logic [NSRC-1:0]        en_wval,
  input  logic [PRIO_W-1:0]      thr_wval,
  output logic [NCTX*NSRC-1:0]   en_flat,
  output logic [NCTX*PRIO_W-1:0] thr_flat
);

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [NSRC-1:0]   en_r;
    logic [PRIO_W-1:0] thr_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_r  <= '0;
        thr_r <= '0;
      end else begin
        if (en_we && ctx == 8'(c))  en_r  <= en_wval;
        if (thr_we && ctx == 8'(c)) thr_r <= thr_wval;
      end
    end

    assign en_flat[c*NSRC +: NSRC]       = en_r;
    assign thr_flat[c*PRIO_W +: PRIO_W]  = thr_r;
  end

endmodule

// File: rtl/irq_claim_regs.sv
module irq_claim_regs
  import irq_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             bus_valid,
  output logic                             bus_ready,
  input  logic                             bus_write,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [31:0]                      bus_wdata,
  output logic                             bus_rsp,
  output logic [31:0]                      bus_rdata,
  input  logic [NSRC-1:0]                  gw_req,
  output logic [NSRC-1:0]                  gw_done,
  input  logic [NCTX*$clog2(NSRC+1)-1:0]   sel_id,
  output logic [NSRC-1:0]                  src_pend,
  output logic [NSRC*PRIO_W-1:0]           src_prio,
  output logic [NCTX*NSRC-1:0]             ctx_en,
  output logic [NCTX*PRIO_W-1:0]           ctx_thr
);

  localparam int ID_W  = $clog2(NSRC + 1);
  localparam int NWORD = (NSRC + 32) / 32;
  localparam int PADW  = NWORD * 32;

  reg_sel_t          sel;
  logic              acc;
  logic              prio_we, en_we, thr_we, claim_rd, cmp_wr;
  logic [PRIO_W-1:0] prio_rval;
  logic [ID_W-1:0]   win;
  logic [PRIO_W-1:0] thr_cur;
  logic [NSRC-1:0]   en_cur;
  logic [PADW-1:0]   pend_pad, en_pad;
  logic [31:0]       rd;
  logic [NSRC-1:0]   cmp_mask;

  assign bus_ready = 1'b1;
  assign acc       = bus_valid & bus_ready;

  irq_addr_decode #(
    .ADDR_W(ADDR_W), .NSRC(NSRC), .NCTX(NCTX), .NWORD(NWORD)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  assign prio_we  = acc &  bus_write & (sel.kind == REG_PRIO);
  assign en_we    = acc &  bus_write & (sel.kind == REG_EN);
  assign thr_we   = acc &  bus_write & (sel.kind == REG_THR);
  assign claim_rd = acc & ~bus_write & (sel.kind == REG_CLAIM);
  assign cmp_wr   = acc &  bus_write & (sel.kind == REG_CLAIM);

  irq_prio_file #(
    .NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
  ) u_prio (
    .clk      (clk),
    .rst      (rst),
    .we       (prio_we),
    .wid      (ID_W'(sel.idx)),
    .wval     (bus_wdata[PRIO_W-1:0]),
    .rid      (ID_W'(sel.idx)),
    .rval     (prio_rval),
    .prio_flat(src_prio)
  );

  irq_pend_track #(
    .NSRC(NSRC), .ID_W(ID_W)
  ) u_pend (
    .clk    (clk),
    .rst    (rst),
    .req    (gw_req),
    .clr_hit(claim_rd),
    .clr_id (win),
    .pend   (src_pend)
  );

  irq_ctx_regs #(
    .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)
  ) u_ctx (
    .clk     (clk),
    .rst     (rst),
    .en_we   (en_we),
    .thr_we  (thr_we),
    .ctx     (sel.ctx),
    .en_wval (bus_wdata[NSRC:1]),
    .thr_wval(bus_wdata[PRIO_W-1:0]),
    .en_flat (ctx_en),
    .thr_flat(ctx_thr)
  );

  // Per-context view selected by the decoded context number.
  always_comb begin
    win     = '0;
    thr_cur = '0;
    en_cur  = '0;
    for (int c = 0; c < NCTX; c++) begin
      if (32'(sel.ctx) == c) begin
        win     = sel_id[c*ID_W +: ID_W];
        thr_cur = ctx_thr[c*PRIO_W +: PRIO_W];
        en_cur  = ctx_en[c*NSRC +: NSRC];
      end
    end
  end

  assign pend_pad = PADW'({src_pend, 1'b0});
  assign en_pad   = PADW'({en_cur, 1'b0});

  always_comb begin
    rd = '0;
    case (sel.kind)
      REG_PRIO:  rd = 32'(prio_rval);
      REG_PEND:  for (int w = 0; w < NWORD; w++)
                   if (32'(sel.idx) == w) rd = pend_pad[w*32 +: 32];
      REG_EN:    for (int w = 0; w < NWORD; w++)
                   if (32'(sel.idx) == w) rd = en_pad[w*32 +: 32];
      REG_THR:   rd = 32'(thr_cur);
      REG_CLAIM: rd = 32'(win);
      default:   rd = '0;
    endcase
  end

  // Completion: checked only against the writing context's enables.
  for (genvar k = 0; k < NSRC; k++) begin : g_cmp
    assign cmp_mask[k] = cmp_wr && (bus_wdata == 32'(k + 1)) && en_cur[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rsp   <= 1'b0;
      bus_rdata <= '0;
      gw_done   <= '0;
    end else begin
      bus_rsp   <= acc;
      bus_rdata <= (acc && !bus_write) ? rd : 32'd0;
      gw_done   <= cmp_mask;
    end
  end

endmodule

// File: rtl/irq_claim_regs_chk.sv
module irq_claim_regs_chk #(
  parameter int ADDR_W = 26,
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           bus_valid,
  input logic                           bus_ready,
  input logic                           bus_write,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic                           bus_rsp,
  input logic [31:0]                    bus_rdata,
  input logic [NCTX*$clog2(NSRC+1)-1:0] sel_id,
  input logic [NSRC-1:0]                src_pend,
  input logic [NSRC-1:0]                gw_done
);

  localparam int ID_W = $clog2(NSRC + 1);
  localparam logic [ADDR_W-1:0] CTX_BASE = ADDR_W'(32'h0020_0000);
  localparam logic [ADDR_W-1:0] CTX_END  = ADDR_W'(32'h0020_0000 + 32'h1000 * NCTX);
  localparam logic [ADDR_W-1:0] PEND_LO  = ADDR_W'(32'h0000_1000);

  logic              acc, at_claim, claim_rd, cmp_wr, prio_rd;
  logic [ADDR_W-1:0] off;
  logic [ID_W-1:0]   cid, cid_q;

  assign acc      = bus_valid && bus_ready;
  assign off      = bus_addr - CTX_BASE;
  assign at_claim = bus_addr >= CTX_BASE && bus_addr < CTX_END && off[11:0] == 12'h004;
  assign claim_rd = acc && !bus_write && at_claim;
  assign cmp_wr   = acc && bus_write && at_claim;
  assign prio_rd  = acc && !bus_write && bus_addr < PEND_LO;

  always_comb begin
    cid = '0;
    for (int c = 0; c < NCTX; c++)
      if (32'(off >> 12) == c) cid = sel_id[c*ID_W +: ID_W];
  end

  always_ff @(posedge clk) begin
    if (rst) cid_q <= '0;
    else     cid_q <= cid;
  end

  p_claim_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (claim_rd && cid != '0) |=> !src_pend[cid_q - 1'b1]);

  p_no_sw_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (|($past(src_pend) & ~src_pend)) |-> $past(claim_rd));

  p_done_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gw_done));

  p_done_from_write_r8: assert property (@(posedge clk) disable iff (rst)
    (|gw_done) |-> $past(cmp_wr));

  p_prio_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rsp && $past(prio_rd)) |-> ((bus_rdata >> PRIO_W) == 32'd0));

  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (rst)
    acc |=> bus_rsp);

endmodule

bind irq_claim_regs irq_claim_regs_chk #(
  .ADDR_W(ADDR_W), .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_valid(bus_valid),
  .bus_ready(bus_ready),
  .bus_write(bus_write),
  .bus_addr (bus_addr),
  .bus_rsp  (bus_rsp),
  .bus_rdata(bus_rdata),
  .sel_id   (sel_id),
  .src_pend (src_pend),
  .gw_done  (gw_done)
);

// File: tb/irq_claim_regs_test.sv
module irq_claim_regs_test;

  localparam int ADDR_W = 26;
  localparam int NSRC   = 31;
  localparam int NCTX   = 2;
  localparam int PRIO_W = 3;
  localparam int ID_W   = $clog2(NSRC + 1);

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   bus_valid = 1'b0;
  logic                   bus_ready;
  logic                   bus_write = 1'b0;
  logic [ADDR_W-1:0]      bus_addr = '0;
  logic [31:0]            bus_wdata = '0;
  logic                   bus_rsp;
  logic [31:0]            bus_rdata;
  logic [NSRC-1:0]        gw_req = '0;
  logic [NSRC-1:0]        gw_done;
  logic [NCTX*ID_W-1:0]   sel_id = '0;
  logic [NSRC-1:0]        src_pend;
  logic [NSRC*PRIO_W-1:0] src_prio;
  logic [NCTX*NSRC-1:0]   ctx_en;
  logic [NCTX*PRIO_W-1:0] ctx_thr;

  int checks = 0;
  int errors = 0;
  logic last_rsp;

  always #2 clk = ~clk;

  irq_claim_regs #(
    .ADDR_W(ADDR_W), .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)
  ) uut (.*);

  function automatic logic [ADDR_W-1:0] a_prio(int id);  return ADDR_W'(4 * id); endfunction
  function automatic logic [ADDR_W-1:0] a_en(int c);     return ADDR_W'(32'h2000 + 32'h80 * c); endfunction
  function automatic logic [ADDR_W-1:0] a_thr(int c);    return ADDR_W'(32'h20_0000 + 32'h1000 * c); endfunction
  function automatic logic [ADDR_W-1:0] a_claim(int c);  return ADDR_W'(32'h20_0004 + 32'h1000 * c); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
    last_rsp = bus_rsp;
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] wd,
                        output logic [NSRC-1:0] dn);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    dn = gw_done;
    last_rsp = bus_rsp;
  endtask

  task automatic set_sel(input int c, input int id);
    sel_id[c*ID_W +: ID_W] = ID_W'(id);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0]     d;
    logic [NSRC-1:0] dn;
    logic [31:0]     exp_pend;
    logic [31:0]     en_word [NCTX];

    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 pending", 32'(src_pend), 0);
    chk("R1 done", 32'(gw_done), 0);
    chk("R1 rsp", 32'(bus_rsp), 0);
    chk("R1 enables", 32'(ctx_en[31:0]), 0);
    bus_rd(a_prio(5), d);  chk("R1 prio", d, 0);
    bus_rd(a_thr(1), d);   chk("R1 thr", d, 0);
    bus_rd(32'h1000, d);   chk("R1 pend word", d, 0);

    // R12: ready and response
    chk("R12 ready", 32'(bus_ready), 1);
    chk("R12 rsp", 32'(last_rsp), 1);
    bus_wr(a_prio(2), 32'h0, dn);
    chk("R12 wr rsp", 32'(last_rsp), 1);

    // R2: priority sweep
    for (int id = 0; id <= NSRC; id++)
      bus_wr(a_prio(id), 32'hFFFF_FFF8 | 32'(id % 8), dn);
    for (int id = 0; id <= NSRC; id++) begin
      bus_rd(a_prio(id), d);
      chk("R2 prio read", d, (id == 0) ? 0 : 32'(id % 8));
      if (id > 0)
        chk("R2 prio port", 32'(src_prio[(id-1)*PRIO_W +: PRIO_W]), 32'(id % 8));
    end

    // R5: enables
    bus_wr(a_en(0), 32'hFFFF_FFFF, dn);
    bus_wr(a_en(1), 32'h0000_00AA, dn);
    bus_rd(a_en(0), d); chk("R5 en ctx0", d, 32'hFFFF_FFFE);
    bus_rd(a_en(1), d); chk("R5 en ctx1", d, 32'h0000_00AA);
    chk("R5 en port0", 32'(ctx_en[0 +: NSRC]), 32'h7FFF_FFFF);
    chk("R5 en port1", 32'(ctx_en[NSRC +: NSRC]), 32'h0000_0055);
    en_word[0] = 32'hFFFF_FFFE;
    en_word[1] = 32'h0000_00AA;

    // R6: thresholds
    bus_wr(a_thr(0), 32'hFFFF_FFFD, dn);
    bus_wr(a_thr(1), 32'h0000_0002, dn);
    bus_rd(a_thr(0), d); chk("R6 thr ctx0", d, 5);
    bus_rd(a_thr(1), d); chk("R6 thr ctx1", d, 2);
    chk("R6 thr port", 32'(ctx_thr), 32'h0000_0015);

    // R3: requests on odd IDs
    @(negedge clk);
    for (int k = 0; k < NSRC; k += 2) gw_req[k] = 1'b1;
    @(negedge clk);
    gw_req = '0;
    chk("R3 pend port", 32'(src_pend), 32'h5555_5555);
    bus_rd(32'h1000, d); chk("R3 pend word", d, 32'hAAAA_AAAA);

    // R4: writes to pending do nothing
    bus_wr(32'h1000, 32'h0, dn);
    bus_rd(32'h1000, d); chk("R4 pend after write 0", d, 32'hAAAA_AAAA);
    bus_wr(32'h1000, 32'hFFFF_FFFF, dn);
    bus_rd(32'h1000, d); chk("R4 pend after write 1s", d, 32'hAAAA_AAAA);

    // R7: claim with no winner, then claim every pending source
    set_sel(0, 0);
    bus_rd(a_claim(0), d); chk("R7 empty claim", d, 0);
    bus_rd(32'h1000, d);   chk("R7 empty claim keeps pend", d, 32'hAAAA_AAAA);
    exp_pend = 32'hAAAA_AAAA;
    for (int id = 1; id <= NSRC; id += 2) begin
      set_sel(id % 2 == 1 && (id / 2) % 2 == 1 ? 1 : 0, id);
      bus_rd(a_claim((id / 2) % 2), d);
      chk("R7 claim id", d, 32'(id));
      exp_pend &= ~(32'h1 << id);
      bus_rd(32'h1000, d);
      chk("R7 pend after claim", d, exp_pend);
    end
    sel_id = '0;

    // R10: request and claim of one source in one cycle
    @(negedge clk); gw_req[8] = 1'b1;
    @(negedge clk); gw_req = '0;
    set_sel(0, 9);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a_claim(0); gw_req[8] = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; gw_req = '0;
    chk("R10 claim data", bus_rdata, 9);
    chk("R10 cleared first", 32'(src_pend[8]), 0);
    @(negedge clk);
    chk("R10 set again", 32'(src_pend[8]), 1);
    bus_rd(32'h1000, d); chk("R10 pend word", d, 32'h0000_0200);
    bus_rd(a_claim(0), d); chk("R10 reclaim", d, 9);
    sel_id = '0;

    // R8/R9: completion sweep per context
    for (int c = 0; c < NCTX; c++) begin
      for (int id = 0; id <= NSRC + 2; id++) begin
        logic [31:0] exp_dn;
        exp_dn = (id >= 1 && id <= NSRC && en_word[c][id]) ? (32'h1 << (id - 1)) : 0;
        bus_wr(a_claim(c), 32'(id), dn);
        chk((exp_dn != 0) ? "R8 completion pulse" : "R9 completion dropped", 32'(dn), exp_dn);
        @(negedge clk);
        chk("R8 pulse one cycle", 32'(gw_done), 0);
      end
    end
    bus_wr(a_claim(0), 32'h8000_0003, dn); chk("R9 high bits dropped", 32'(dn), 0);
    bus_wr(a_claim(1), 32'hFFFF_FFFF, dn); chk("R9 all ones dropped", 32'(dn), 0);

    // R11: unmapped offsets
    begin
      logic [ADDR_W-1:0] um [9];
      um[0] = 26'h000_0080; um[1] = 26'h000_0FFC; um[2] = 26'h000_1004;
      um[3] = 26'h000_1FFC; um[4] = 26'h000_2004; um[5] = 26'h000_2100;
      um[6] = 26'h020_0008; um[7] = 26'h020_2000; um[8] = 26'h3FF_FFFC;
      for (int i = 0; i < 9; i++) bus_wr(um[i], 32'hFFFF_FFFF, dn);
      for (int i = 0; i < 9; i++) begin
        bus_rd(um[i], d);
        chk("R11 unmapped read", d, 0);
      end
    end
    bus_rd(a_thr(0), d);   chk("R11 thr0 kept", d, 5);
    bus_rd(a_thr(1), d);   chk("R11 thr1 kept", d, 2);
    bus_rd(a_en(1), d);    chk("R11 en1 kept", d, 32'h0000_00AA);
    bus_rd(a_prio(31), d); chk("R11 prio kept", d, 7);
    bus_rd(32'h1000, d);   chk("R11 pend kept", d, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule